// File: doc/BRIEF.md
# Conditional Debug Breakpoint Comparator

This block watches a stream of bus events and raises a trap when an event hits one programmed breakpoint. Each event has a kind, an address and a 32-bit data value. The kind is one of five: memory write, memory read, instruction fetch, port input or port output.

The breakpoint has the following settings:
- a class, which chooses fetch, memory or port events;
- a base address;
- a 12-bit mask that ignores chosen low address bits;
- a data match value and a data compare mask;
- a small control field.

The control field can limit a port breakpoint to one direction. It can also turn on the data condition and invert it, so the trap fires on a mismatch.

Software loads the registers through a write port. Every write must carry a fixed 32-bit key. A write with any other key is dropped and sets a sticky error flag.

The trap output is a registered pulse. It rises in the cycle after the qualifying event is presented.

Top module: `dbg_bkpt_unit`

## Requirements
- R1: After reset, `trap_o` and `key_err_o` are 0. All breakpoint registers are 0, and class 0 means the breakpoint is off, so no event traps.
- R2: A write with `cfg_we`=1 and `cfg_key` equal to the KEY parameter loads the register chosen by `cfg_sel`. The new value applies to events from the next cycle on.
  - Select codes: 0 base address, 1 address mask, 2 data match, 3 data mask, 4 control, 5 class. Other select codes change nothing.
  - A write with any other key changes no register and sets `key_err_o`. The flag stays set until reset.
- R3: The address matches when every address bit not ignored equals the base.
  - Only address bits 11:0 can be ignored, and address mask bit i ignores address bit i.
  - An all-zero mask requires an exact match. Bits above 11 are always compared.
- R4: Event kind codes: 0 memory write, 1 memory read, 2 fetch, 3 port input, 4 port output. Class codes: 0 off, 1 fetch, 2 memory, 3 port. A breakpoint only fires on events of its own class.
- R5: For a port breakpoint, control bit 1 blocks port input, so only output fires. Control bit 3 blocks port output, so only input fires. With both bits clear, both directions fire.
- R6: The data condition is on when control bit 1 or bit 3 is set.
  - The data passes when ((ev_data XOR match) AND mask) == 0. A zero mask passes every value.
  - Control bit 0 inverts the pass result while the data condition is on. With the condition off, data is never compared.
- R7: A memory breakpoint with the data condition off fires on reads and writes in range. With the data condition on, it fires only on writes that meet the data condition.
- R8: A fetch breakpoint depends only on the address compare. The control field and the data registers have no effect on it.
- R9: `trap_o` is 1 in the cycle after a valid event that hits while `enable` is 1. It is 0 in every other cycle, so each hit gives a pulse one cycle wide. While `enable` is 0, no trap is raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Global breakpoint enable |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select |
| cfg_key | input | 32 | Key presented with the write |
| cfg_wdata | input | 32 | Register write data |
| ev_valid | input | 1 | Bus event present |
| ev_kind | input | 3 | Event kind code |
| ev_addr | input | 32 | Event address |
| ev_data | input | 32 | Event data |
| trap_o | output | 1 | Registered trap pulse |
| key_err_o | output | 1 | Sticky flag set by a write with a bad key |

## Verification
A wrong register value or a wrongly accepted write cannot be seen until an event probes it. The first event that crosses the corrupted field then shows a missing or extra `trap_o` pulse, exactly one cycle later. For this reason the bench follows every configuration change with events placed on and just off each mask boundary. A bad-key write that slips through shows up at once as `key_err_o` staying low, or later as a trap on an address the bench never allowed.

// File: rtl/dbg_bkpt_pkg.sv
package dbg_bkpt_pkg;

  typedef enum logic [2:0] {
    EV_MWR   = 3'd0,
    EV_MRD   = 3'd1,
    EV_FETCH = 3'd2,
    EV_PIN   = 3'd3,
    EV_POUT  = 3'd4
  } ev_kind_e;

  typedef enum logic [1:0] {
    BP_OFF   = 2'd0,
    BP_FETCH = 2'd1,
    BP_MEM   = 2'd2,
    BP_PORT  = 2'd3
  } bp_class_e;

  localparam logic [2:0] SEL_BASE  = 3'd0;
  localparam logic [2:0] SEL_AMASK = 3'd1;
  localparam logic [2:0] SEL_DMAT  = 3'd2;
  localparam logic [2:0] SEL_DMASK = 3'd3;
  localparam logic [2:0] SEL_CTRL  = 3'd4;
  localparam logic [2:0] SEL_CLASS = 3'd5;

  localparam int CTRL_W = 4;

endpackage

// File: rtl/dbg_bkpt_regs.sv
module dbg_bkpt_regs
  import dbg_bkpt_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int MW = 12,
  parameter logic [31:0] KEY = 32'h5A3C_96E1,
  localparam int WW = (AW > DW) ? AW : DW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_sel,
  input  logic [31:0]       cfg_key,
  input  logic [WW-1:0]     cfg_wdata,
  output logic [AW-1:0]     base,
  output logic [MW-1:0]     amask,
  output logic [DW-1:0]     dmat,
  output logic [DW-1:0]     dmask,
  output logic [CTRL_W-1:0] ctrl,
  output bp_class_e         bclass,
  output logic              key_err
);

  logic key_ok;
  assign key_ok = (cfg_key == KEY);

  always_ff @(posedge clk) begin
    if (rst) begin
      base    <= '0;
      amask   <= '0;
      dmat    <= '0;
      dmask   <= '0;
      ctrl    <= '0;
      bclass  <= BP_OFF;
      key_err <= 1'b0;
    end else if (cfg_we) begin
      if (!key_ok) begin
        key_err <= 1'b1;
      end else begin
        case (cfg_sel)
          SEL_BASE:  base   <= cfg_wdata[AW-1:0];
          SEL_AMASK: amask  <= cfg_wdata[MW-1:0];
          SEL_DMAT:  dmat   <= cfg_wdata[DW-1:0];
          SEL_DMASK: dmask  <= cfg_wdata[DW-1:0];
          SEL_CTRL:  ctrl   <= cfg_wdata[CTRL_W-1:0];
          SEL_CLASS: bclass <= bp_class_e'(cfg_wdata[1:0]);
          default: ;
        endcase
      end
    end
  end

  // R2: the error flag is sticky until reset
  assert_key_sticky_R2: assert property (@(posedge clk) disable iff (rst)
    key_err |=> key_err);

  // R2: a write with a bad key leaves every register as it was
  assert_bad_key_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_key != KEY) |=> ($stable(base) && $stable(amask) &&
      $stable(dmat) && $stable(dmask) && $stable(ctrl) && $stable(bclass)));

endmodule

// File: rtl/dbg_bkpt_match.sv
module dbg_bkpt_match
  import dbg_bkpt_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int MW = 12
) (
  input  logic [2:0]        ev_kind,
  input  logic [AW-1:0]     ev_addr,
  input  logic [DW-1:0]     ev_data,
  input  logic [AW-1:0]     base,
  input  logic [MW-1:0]     amask,
  input  logic [DW-1:0]     dmat,
  input  logic [DW-1:0]     dmask,
  input  logic [CTRL_W-1:0] ctrl,
  input  bp_class_e         bclass,
  output logic              addr_eq,
  output logic              hit
);

  logic [AW-1:0] care;

  genvar gi;
  generate
    for (gi = 0; gi < AW; gi++) begin : g_care
      if (gi < MW) begin : g_low
        assign care[gi] = ~amask[gi];
      end else begin : g_high
        assign care[gi] = 1'b1;
      end
    end
  endgenerate

  assign addr_eq = (((ev_addr ^ base) & care) == '0);

  logic dcmp_en, dpass, dcond;
  logic in_ok, out_ok;

  always_comb begin
    dcmp_en = ctrl[1] | ctrl[3];
    dpass   = (((ev_data ^ dmat) & dmask) == '0);
    dcond   = dcmp_en ? (dpass ^ ctrl[0]) : 1'b1;
    in_ok   = ~ctrl[1];
    out_ok  = ~ctrl[3];
    hit     = 1'b0;
    case (bclass)
      BP_FETCH: hit = addr_eq && (ev_kind == EV_FETCH);
      BP_MEM:   hit = addr_eq &&
                      (((ev_kind == EV_MWR) && dcond) ||
                       ((ev_kind == EV_MRD) && !dcmp_en));
      BP_PORT:  hit = addr_eq && dcond &&
                      (((ev_kind == EV_PIN) && in_ok) ||
                       ((ev_kind == EV_POUT) && out_ok));
      default:  hit = 1'b0;
    endcase
  end

endmodule

// File: rtl/dbg_bkpt_unit.sv
module dbg_bkpt_unit
  import dbg_bkpt_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int MW = 12,
  parameter logic [31:0] KEY = 32'h5A3C_96E1,
  localparam int WW = (AW > DW) ? AW : DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          enable,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_sel,
  input  logic [31:0]   cfg_key,
  input  logic [WW-1:0] cfg_wdata,
  input  logic          ev_valid,
  input  logic [2:0]    ev_kind,
  input  logic [AW-1:0] ev_addr,
  input  logic [DW-1:0] ev_data,
  output logic          trap_o,
  output logic          key_err_o
);

  logic [AW-1:0]     base;
  logic [MW-1:0]     amask;
  logic [DW-1:0]     dmat, dmask;
  logic [CTRL_W-1:0] ctrl;
  bp_class_e         bclass;
  logic              addr_eq, hit;

  dbg_bkpt_regs #(.AW(AW), .DW(DW), .MW(MW), .KEY(KEY)) u_regs (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_key(cfg_key), .cfg_wdata(cfg_wdata), .base(base), .amask(amask),
    .dmat(dmat), .dmask(dmask), .ctrl(ctrl), .bclass(bclass),
    .key_err(key_err_o)
  );

  dbg_bkpt_match #(.AW(AW), .DW(DW), .MW(MW)) u_match (
    .ev_kind(ev_kind), .ev_addr(ev_addr), .ev_data(ev_data), .base(base),
    .amask(amask), .dmat(dmat), .dmask(dmask), .ctrl(ctrl),
    .bclass(bclass), .addr_eq(addr_eq), .hit(hit)
  );

  always_ff @(posedge clk) begin
    if (rst) trap_o <= 1'b0;
    else     trap_o <= enable && ev_valid && hit;
  end

  // R9: a trap always follows a valid event seen while enabled
  assert_trap_after_event_R9: assert property (@(posedge clk) disable iff (rst)
    trap_o |-> $past(ev_valid && enable));

  // R9: no trap in the cycle after enable was low
  assert_disabled_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    !enable |=> !trap_o);

  // R4: a breakpoint of class off never traps
  assert_class_off_R4: assert property (@(posedge clk) disable iff (rst)
    (bclass == BP_OFF) |=> !trap_o);

  // R3: address bits above the mask are always compared
  assert_upper_exact_R3: assert property (@(posedge clk) disable iff (rst)
    trap_o |-> ($past(ev_addr[AW-1:MW]) == $past(base[AW-1:MW])));

  // R8: a fetch in range under a fetch breakpoint always traps
  assert_fetch_addr_only_R8: assert property (@(posedge clk) disable iff (rst)
    (ev_valid && enable && bclass == BP_FETCH && ev_kind == EV_FETCH && addr_eq)
      |=> trap_o);

  // R6: an inverted compare with a zero data mask never fires
  assert_inv_zero_mask_R6: assert property (@(posedge clk) disable iff (rst)
    (ev_valid && bclass == BP_PORT && ctrl[0] && (ctrl[1] || ctrl[3]) &&
     dmask == '0) |=> !trap_o);

endmodule

// File: tb/sim_dbg_bkpt_unit.sv
module sim_dbg_bkpt_unit;

  localparam logic [31:0] KEY = 32'h5A3C_96E1;

  logic        clk = 1'b0;
  logic        rst, enable, cfg_we, ev_valid;
  logic [2:0]  cfg_sel, ev_kind;
  logic [31:0] cfg_key, cfg_wdata, ev_addr, ev_data;
  logic        trap_o, key_err_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  logic [31:0] m_base, m_dmat, m_dmask;
  logic [11:0] m_amask;
  logic [3:0]  m_ctrl;
  logic [1:0]  m_class;

  always #2 clk = ~clk;

  dbg_bkpt_unit #(.KEY(KEY)) u0 (
    .clk(clk), .rst(rst), .enable(enable), .cfg_we(cfg_we),
    .cfg_sel(cfg_sel), .cfg_key(cfg_key), .cfg_wdata(cfg_wdata),
    .ev_valid(ev_valid), .ev_kind(ev_kind), .ev_addr(ev_addr),
    .ev_data(ev_data), .trap_o(trap_o), .key_err_o(key_err_o)
  );

  function automatic bit exp_hit(input logic [2:0] k, input logic [31:0] a,
                                 input logic [31:0] d);
    bit aeq, dce, dc;
    aeq = ((a ^ m_base) & ~{20'h0, m_amask}) == 32'h0;
    dce = m_ctrl[1] | m_ctrl[3];
    dc  = dce ? ((((d ^ m_dmat) & m_dmask) == 32'h0) ^ m_ctrl[0]) : 1'b1;
    case (m_class)
      2'd1: return aeq && k == 3'd2;
      2'd2: return aeq && ((k == 3'd0 && dc) || (k == 3'd1 && !dce));
      2'd3: return aeq && dc && ((k == 3'd3 && !m_ctrl[1]) ||
                                 (k == 3'd4 && !m_ctrl[3]));
      default: return 1'b0;
    endcase
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [31:0] val,
                    input logic [31:0] key);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val; cfg_key = key;
    @(negedge clk);
    cfg_we = 1'b0;
    if (key == KEY) begin
      case (sel)
        3'd0: m_base  = val;
        3'd1: m_amask = val[11:0];
        3'd2: m_dmat  = val;
        3'd3: m_dmask = val;
        3'd4: m_ctrl  = val[3:0];
        3'd5: m_class = val[1:0];
        default: ;
      endcase
    end
  endtask

  task automatic cfg(input logic [1:0] cl, input logic [31:0] b,
                     input logic [11:0] am, input logic [3:0] c,
                     input logic [31:0] dm, input logic [31:0] dk);
    wr(3'd0, b, KEY); wr(3'd1, {20'h0, am}, KEY); wr(3'd2, dm, KEY);
    wr(3'd3, dk, KEY); wr(3'd4, {28'h0, c}, KEY); wr(3'd5, {30'h0, cl}, KEY);
  endtask

  // drive event, check trap one cycle later
  task automatic ev(input string req, input logic [2:0] k,
                    input logic [31:0] a, input logic [31:0] d);
    logic e;
    e = enable && exp_hit(k, a, d);
    ev_valid = 1'b1; ev_kind = k; ev_addr = a; ev_data = d;
    @(negedge clk);
    ev_valid = 1'b0;
    check(req, trap_o, e);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4321));
    rst = 1'b1; enable = 1'b1; cfg_we = 1'b0; cfg_sel = '0; cfg_key = '0;
    cfg_wdata = '0; ev_valid = 1'b0; ev_kind = '0; ev_addr = '0; ev_data = '0;
    m_base = '0; m_amask = '0; m_dmat = '0; m_dmask = '0; m_ctrl = '0;
    m_class = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 trap", trap_o, 1'b0);
    check("R1 key_err", key_err_o, 1'b0);
    ev("R1 off after reset", 3'd2, 32'h0, 32'h0);
    ev("R1 off after reset", 3'd0, 32'h0, 32'h0);

    // R2 key handling
    wr(3'd5, 32'd1, 32'hDEAD_BEEF);
    check("R2 bad key flag", key_err_o, 1'b1);
    ev("R2 bad key dropped", 3'd2, 32'h0, 32'h0);
    wr(3'd5, 32'd1, KEY);
    ev("R2 good key loads", 3'd2, 32'h0, 32'h0);
    check("R2 flag sticky", key_err_o, 1'b1);
    wr(3'd6, 32'd0, KEY);
    ev("R2 unused select", 3'd2, 32'h0, 32'h0);

    // R3 exact and masked address, R8 fetch ignores ctrl/data
    cfg(2'd1, 32'h1234_5000, 12'h000, 4'hB, 32'h1, 32'hFFFF_FFFF);
    ev("R3 exact hit", 3'd2, 32'h1234_5000, 32'h0);
    ev("R3 exact miss", 3'd2, 32'h1234_5001, 32'h0);
    ev("R8 fetch data ignored", 3'd2, 32'h1234_5000, 32'h5555);
    wr(3'd1, 32'hFFF, KEY);
    ev("R3 full range top", 3'd2, 32'h1234_5FFF, 32'h0);
    ev("R3 upper bit exact", 3'd2, 32'h1234_6000, 32'h0);
    ev("R4 wrong class", 3'd0, 32'h1234_5000, 32'h0);

    // R5 R6 port modes
    cfg(2'd3, 32'h0000_0060, 12'h00F, 4'h0, 32'hAB, 32'hFF);
    ev("R5 ctrl0 input", 3'd3, 32'h0000_0064, 32'h0);
    ev("R5 ctrl0 output", 3'd4, 32'h0000_006F, 32'h0);
    ev("R4 port miss mem", 3'd0, 32'h0000_0060, 32'h0);
    wr(3'd4, 32'h2, KEY);
    ev("R5 out only blocks in", 3'd3, 32'h60, 32'hAB);
    ev("R6 out data match", 3'd4, 32'h60, 32'h12AB);
    ev("R6 out data miss", 3'd4, 32'h60, 32'hAC);
    wr(3'd4, 32'h3, KEY);
    ev("R6 inverted match", 3'd4, 32'h60, 32'hAB);
    ev("R6 inverted miss", 3'd4, 32'h60, 32'hAC);
    wr(3'd4, 32'h8, KEY);
    ev("R5 in only blocks out", 3'd4, 32'h60, 32'hAB);
    ev("R5 in data match", 3'd3, 32'h60, 32'hAB);
    wr(3'd4, 32'h9, KEY);
    ev("R6 in inverted", 3'd3, 32'h60, 32'h00);
    wr(3'd3, 32'h0, KEY);
    ev("R6 zero mask inverted", 3'd3, 32'h60, 32'h00);

    // R7 memory
    cfg(2'd2, 32'h8000_0100, 12'h003, 4'h0, 32'h77, 32'hFF);
    ev("R7 read no compare", 3'd1, 32'h8000_0102, 32'h0);
    ev("R7 write no compare", 3'd0, 32'h8000_0103, 32'h0);
    wr(3'd4, 32'h2, KEY);
    ev("R7 read with compare", 3'd1, 32'h8000_0100, 32'h77);
    ev("R7 write match", 3'd0, 32'h8000_0100, 32'h77);
    ev("R7 write miss", 3'd0, 32'h8000_0100, 32'h78);

    // R9 timing and enable
    ev("R9 back to back a", 3'd0, 32'h8000_0100, 32'h77);
    ev("R9 back to back b", 3'd0, 32'h8000_0101, 32'h78);
    @(negedge clk);
    check("R9 single pulse", trap_o, 1'b0);
    enable = 1'b0;
    ev("R9 enable low", 3'd0, 32'h8000_0100, 32'h77);
    enable = 1'b1;

    // random mix, all requirements
    for (int c = 0; c < 40; c++) begin
      cfg(2'($urandom_range(0, 3)), $urandom, 12'($urandom),
          4'($urandom), $urandom, ($urandom_range(0, 3) == 0) ? 32'h0 : $urandom);
      for (int e = 0; e < 25; e++) begin
        logic [31:0] a, d;
        a = m_base ^ {20'h0, 12'($urandom)};
        if ($urandom_range(0, 4) == 0) a = a ^ (32'h1000 << $urandom_range(0, 19));
        d = ($urandom_range(0, 1) == 0) ? (m_dmat ^ ($urandom & ~m_dmask)) : $urandom;
        enable = ($urandom_range(0, 9) != 0);
        ev("R3 R4 R5 R6 R7 R8 random", 3'($urandom_range(0, 4)), a, d);
      end
    end
    enable = 1'b1;

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule